// File: doc/BRIEF.md
# Virtually Tagged Cache Lookup and Protection Check

This block decides, for every CPU read and write, whether a direct-mapped, write-through cache indexed and tagged by virtual word address can serve the access. It holds the tag and data arrays. Each tag stores the upper address bits, a valid flag, the supervisor and writable attributes copied from the page entry at fill time, and the context that caused the fill. Because of this, a user-mode access that hits a line filled by another context from a supervisor page faults inside the cache, with no new translation.

The CPU side presents one request per cycle. The request carries the virtual word address, the privilege level, the current context, the global cache-enable bit and the attributes of the already translated page. One cycle later the block reports the results. These are the hit flag and the read word, a fault flag, a strobe that lets the write reach memory, and a fill request naming the line that was just tagged. The memory side loads a filled line through a fill port. A diagnostic port reads and writes raw tags and data words. A sticky error status and the faulting byte address are kept for the CPU to read.

The tag layout is fixed. Valid is bit 19, supervisor bit 20, writable bit 21, and the context sits at bits 22 and up. The 14-bit identifier sits at bits 15:2 and is taken from the word-address bits just above the cache's own index and offset bits.

Top module: `vtc_lookup`

## Requirements
- R1: After reset every line is invalid (a diagnostic tag read returns 0), and rsp_valid, err_status and err_addr are 0.
- R2: A cacheable read with a valid page entry that finds its line invalid or holding another identifier writes the tag as valid, with the page's supervisor and writable bits, the current context and the identifier. The tag value is 0x80000 | S<<20 | W<<21 | ctx<<22 | id<<2. The read raises fill_req with the line index and reports no hit.
- R3: A cacheable read that finds a valid line with a matching identifier, and that is not protected, reports a hit and returns the stored word.
- R4: A cacheable read that misses while the page entry is invalid leaves the tag unchanged and requests no fill. Any write with an invalid page entry is dropped: no memory write, no fault and no tag change.
- R5: A user-mode cacheable read that hits a valid line whose supervisor bit is set and whose context differs from the current one faults. It returns 0 with no hit, ORs 0x0040 into err_status, latches the byte address in err_addr and invalidates the line.
- R6: A cacheable write that hits a valid, writable, unprotected line updates the cached word, reports a hit and asserts mem_we.
- R7: A cacheable write to an invalid or mismatching line invalidates that line and still asserts mem_we, with no fault.
- R8: A cacheable write that hits a valid line that is not writable, or is protected as in R5, faults. It ORs 0x8040 into err_status, latches the byte address, suppresses mem_we and invalidates the line. Status bits are never cleared except by reset.
- R9: An access is cacheable only when the page type is 0, the page is not uncached and cache_en is 1. Otherwise no tag or data changes and no hit occurs. Reads never fault. A write faults exactly when the page is not writable or is a supervisor page accessed in user mode.
- R10: A diagnostic tag write (dg_sel=0) stores the data masked with 0x03f8fffc. A diagnostic read returns the tag of the line selected by dg_addr one cycle later.
- R11: A diagnostic data write (dg_sel=1) stores the word and clears the valid bit of the line holding it. A diagnostic data read returns the word one cycle later.
- R12: Every result of a request (rsp_valid, rsp_hit, rsp_fault, rsp_rdata, mem_we, fill_req, fill_line, err_status, err_addr) appears exactly one cycle after the request. At most one of req_valid, dg_en and fill_we is high in a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | VA_W | Virtual word address |
| req_wdata | input | 32 | Write data |
| user_mode | input | 1 | 1 = user privilege |
| cur_ctx | input | CTX_W | Current context |
| cache_en | input | 1 | Global cache enable |
| pg_valid | input | 1 | Page entry valid |
| pg_writable | input | 1 | Page writable |
| pg_super | input | 1 | Page supervisor-only |
| pg_uncached | input | 1 | Page marked uncached |
| pg_type | input | 2 | Page space type (0 = main memory) |
| fill_we | input | 1 | Fill word write strobe |
| fill_idx | input | CACHE_AW | Cache word index for fill |
| fill_data | input | 32 | Fill word |
| dg_en | input | 1 | Diagnostic access |
| dg_we | input | 1 | Diagnostic write |
| dg_sel | input | 1 | 0 = tag, 1 = data |
| dg_addr | input | CACHE_AW | Diagnostic cache word index |
| dg_wdata | input | 32 | Diagnostic write data |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_hit | output | 1 | Served by the cache |
| rsp_rdata | output | 32 | Read word (0 unless hit) |
| rsp_fault | output | 1 | Protection fault |
| mem_we | output | 1 | Write may proceed to memory |
| fill_req | output | 1 | Line tagged, data needed |
| fill_line | output | IDX_W | Line to fill |
| dg_rdata | output | 32 | Diagnostic read data |
| err_status | output | 16 | Sticky error status |
| err_addr | output | 32 | Last faulting byte address |

## Verification
All request results are registered, so they are due at the first clock edge after the cycle in which req_valid is high. Diagnostic read data is due at the first edge after dg_en. Tag and data updates are visible to any access issued in the next cycle. The bench changes inputs on the falling edge and samples each result at the next falling edge, half a cycle after the edge that registers it. It also confirms that rsp_valid is high only in that cycle. Fill words are loaded cycle by cycle right after fill_req, before the next request is issued.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    localparam int TAG_V    = 19;
    localparam int TAG_S    = 20;
    localparam int TAG_WR   = 21;
    localparam int TAG_CTX  = 22;
    localparam int ID_LSB   = 2;
    localparam int ID_W     = 14;
    localparam logic [31:0] DIAG_MASK = 32'h03f8_fffc;
    localparam logic [15:0] ST_RD_PROT = 16'h0040;
    localparam logic [15:0] ST_WR_PROT = 16'h8040;
endpackage

// File: rtl/vtc_store.sv
module vtc_store #(
    parameter int NUM_LINES = 32,
    parameter int NUM_WORDS = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NUM_LINES)-1:0] tag_ridx,
    output logic [31:0]                  tag_rd,
    input  logic                         tag_we,
    input  logic [$clog2(NUM_LINES)-1:0] tag_widx,
    input  logic [31:0]                  tag_wd,
    input  logic [$clog2(NUM_WORDS)-1:0] data_ridx,
    output logic [31:0]                  data_rd,
    input  logic                         data_we,
    input  logic [$clog2(NUM_WORDS)-1:0] data_widx,
    input  logic [31:0]                  data_wd
);
    logic [31:0] tags_q [NUM_LINES];
    logic [31:0] words_q [NUM_WORDS];

    assign tag_rd  = tags_q[tag_ridx];
    assign data_rd = words_q[data_ridx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) tags_q[i] <= '0;
        end else if (tag_we) begin
            tags_q[tag_widx] <= tag_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (data_we) words_q[data_widx] <= data_wd;
    end
endmodule

// File: rtl/vtc_decide.sv
module vtc_decide
    import vtc_pkg::*;
#(
    parameter int CTX_W = 3
) (
    input  logic             is_write,
    input  logic             user_mode,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic             cache_en,
    input  logic             pg_valid,
    input  logic             pg_writable,
    input  logic             pg_super,
    input  logic             pg_uncached,
    input  logic [1:0]       pg_type,
    input  logic [ID_W-1:0]  id_in,
    input  logic [31:0]      tag,
    input  logic [31:0]      word,
    output logic             hit,
    output logic             fault,
    output logic             mem_ok,
    output logic             fill,
    output logic             tag_we,
    output logic [31:0]      tag_wd,
    output logic             data_we,
    output logic [31:0]      rdata
);
    logic cacheable, line_ok, prot, wr_ok;

    always_comb begin
        cacheable = (pg_type == 2'd0) && !pg_uncached && cache_en;
        line_ok   = tag[TAG_V] && (tag[ID_LSB +: ID_W] == id_in);
        prot      = user_mode && tag[TAG_S] && (tag[TAG_CTX +: CTX_W] != cur_ctx);
        wr_ok     = tag[TAG_WR];
        hit = 1'b0; fault = 1'b0; mem_ok = 1'b0; fill = 1'b0;
        tag_we = 1'b0; data_we = 1'b0; rdata = '0;
        tag_wd = tag;
        tag_wd[TAG_V] = 1'b0;
        if (!is_write) begin
            if (cacheable && line_ok && prot) begin
                fault  = 1'b1;
                tag_we = 1'b1;
            end else if (cacheable && line_ok) begin
                hit   = 1'b1;
                rdata = word;
            end else if (cacheable && pg_valid) begin
                fill   = 1'b1;
                tag_we = 1'b1;
                tag_wd = '0;
                tag_wd[TAG_V]            = 1'b1;
                tag_wd[TAG_S]            = pg_super;
                tag_wd[TAG_WR]           = pg_writable;
                tag_wd[TAG_CTX +: CTX_W] = cur_ctx;
                tag_wd[ID_LSB +: ID_W]   = id_in;
            end
        end else if (pg_valid) begin
            if (cacheable) begin
                if (line_ok && (!wr_ok || prot)) begin
                    fault  = 1'b1;
                    tag_we = 1'b1;
                end else if (line_ok) begin
                    hit     = 1'b1;
                    data_we = 1'b1;
                    mem_ok  = 1'b1;
                end else begin
                    tag_we = 1'b1;
                    mem_ok = 1'b1;
                end
            end else begin
                fault  = !pg_writable || (user_mode && pg_super);
                mem_ok = !fault;
            end
        end
    end
endmodule

// File: rtl/vtc_lookup.sv
module vtc_lookup
    import vtc_pkg::*;
#(
    parameter int VA_W       = 22,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 32,
    parameter int CTX_W      = 3
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_valid,
    input  logic                                          req_write,
    input  logic [VA_W-1:0]                               req_vaddr,
    input  logic [31:0]                                   req_wdata,
    input  logic                                          user_mode,
    input  logic [CTX_W-1:0]                              cur_ctx,
    input  logic                                          cache_en,
    input  logic                                          pg_valid,
    input  logic                                          pg_writable,
    input  logic                                          pg_super,
    input  logic                                          pg_uncached,
    input  logic [1:0]                                    pg_type,
    input  logic                                          fill_we,
    input  logic [$clog2(LINE_WORDS*NUM_LINES)-1:0]       fill_idx,
    input  logic [31:0]                                   fill_data,
    input  logic                                          dg_en,
    input  logic                                          dg_we,
    input  logic                                          dg_sel,
    input  logic [$clog2(LINE_WORDS*NUM_LINES)-1:0]       dg_addr,
    input  logic [31:0]                                   dg_wdata,
    output logic                                          rsp_valid,
    output logic                                          rsp_hit,
    output logic [31:0]                                   rsp_rdata,
    output logic                                          rsp_fault,
    output logic                                          mem_we,
    output logic                                          fill_req,
    output logic [$clog2(NUM_LINES)-1:0]                  fill_line,
    output logic [31:0]                                   dg_rdata,
    output logic [15:0]                                   err_status,
    output logic [31:0]                                   err_addr
);
    localparam int LS        = $clog2(LINE_WORDS);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int CACHE_AW  = LS + IDX_W;
    localparam int NUM_WORDS = LINE_WORDS * NUM_LINES;

    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_hit;
        logic             rsp_fault;
        logic             rsp_wr;
        logic             mem_we;
        logic             fill_req;
        logic [IDX_W-1:0] fill_line;
        logic [31:0]      rsp_rdata;
        logic [31:0]      dg_rdata;
        logic [15:0]      err_status;
        logic [31:0]      err_addr;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]    tag_ridx, tag_widx;
    logic [CACHE_AW-1:0] data_ridx, data_widx;
    logic [31:0]         tag_rd, data_rd, tag_wd, data_wd;
    logic                tag_we, data_we;
    logic                c_hit, c_fault, c_mem, c_fill, c_tag_we, c_data_we;
    logic [31:0]         c_tag_wd, c_rdata;

    vtc_store #(.NUM_LINES(NUM_LINES), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .tag_ridx(tag_ridx), .tag_rd(tag_rd),
        .tag_we(tag_we), .tag_widx(tag_widx), .tag_wd(tag_wd),
        .data_ridx(data_ridx), .data_rd(data_rd),
        .data_we(data_we), .data_widx(data_widx), .data_wd(data_wd)
    );

    vtc_decide #(.CTX_W(CTX_W)) u_decide (
        .is_write(req_write), .user_mode(user_mode), .cur_ctx(cur_ctx),
        .cache_en(cache_en), .pg_valid(pg_valid), .pg_writable(pg_writable),
        .pg_super(pg_super), .pg_uncached(pg_uncached), .pg_type(pg_type),
        .id_in(req_vaddr[CACHE_AW +: ID_W]), .tag(tag_rd), .word(data_rd),
        .hit(c_hit), .fault(c_fault), .mem_ok(c_mem), .fill(c_fill),
        .tag_we(c_tag_we), .tag_wd(c_tag_wd), .data_we(c_data_we), .rdata(c_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_fault = 1'b0;
        st_d.rsp_wr    = req_write;
        st_d.mem_we    = 1'b0;
        st_d.fill_req  = 1'b0;
        st_d.rsp_rdata = '0;
        tag_ridx  = req_valid ? req_vaddr[LS +: IDX_W] : dg_addr[LS +: IDX_W];
        data_ridx = req_valid ? req_vaddr[CACHE_AW-1:0] : dg_addr;
        tag_widx  = tag_ridx;
        data_widx = data_ridx;
        tag_we    = 1'b0;
        tag_wd    = c_tag_wd;
        data_we   = 1'b0;
        data_wd   = req_wdata;
        if (req_valid) begin
            st_d.rsp_hit   = c_hit;
            st_d.rsp_fault = c_fault;
            st_d.mem_we    = c_mem;
            st_d.fill_req  = c_fill;
            st_d.fill_line = req_vaddr[LS +: IDX_W];
            st_d.rsp_rdata = c_rdata;
            tag_we         = c_tag_we;
            data_we        = c_data_we;
            if (c_fault) begin
                st_d.err_status = st_q.err_status | (req_write ? ST_WR_PROT : ST_RD_PROT);
                st_d.err_addr   = 32'({req_vaddr, 2'b00});
            end
        end else if (dg_en) begin
            if (!dg_we) begin
                st_d.dg_rdata = dg_sel ? data_rd : tag_rd;
            end else if (dg_sel) begin
                data_we = 1'b1;
                data_wd = dg_wdata;
                tag_we  = 1'b1;
                tag_wd  = tag_rd & ~(32'd1 << TAG_V);
            end else begin
                tag_we = 1'b1;
                tag_wd = dg_wdata & DIAG_MASK;
            end
        end else if (fill_we) begin
            data_we   = 1'b1;
            data_widx = fill_idx;
            data_wd   = fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_hit    = st_q.rsp_hit;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign rsp_fault  = st_q.rsp_fault;
    assign mem_we     = st_q.mem_we;
    assign fill_req   = st_q.fill_req;
    assign fill_line  = st_q.fill_line;
    assign dg_rdata   = st_q.dg_rdata;
    assign err_status = st_q.err_status;
    assign err_addr   = st_q.err_addr;

    assert_rsp_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_one_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, dg_en, fill_we}));
    assert_fault_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!rsp_hit && !mem_we && !fill_req));
    assert_rd_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && !st_q.rsp_wr) |-> (rsp_rdata == 32'd0));
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_status & $past(err_status)) == $past(err_status)));
    assert_fill_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (rsp_valid && !st_q.rsp_wr && !rsp_hit));
    assert_fault_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> err_status[6]);
endmodule

// File: tb/sim_vtc_lookup.sv
module sim_vtc_lookup;
    localparam int NL = 32, LW = 8, NW = 256;

    logic clk = 0, rst_n = 0;
    always #10 clk = ~clk;

    logic req_valid = 0, req_write = 0, user_mode = 0, cache_en = 0;
    logic [21:0] req_vaddr = 0;
    logic [31:0] req_wdata = 0, fill_data = 0, dg_wdata = 0;
    logic [2:0] cur_ctx = 0;
    logic pg_valid = 0, pg_writable = 0, pg_super = 0, pg_uncached = 0;
    logic [1:0] pg_type = 0;
    logic fill_we = 0, dg_en = 0, dg_we = 0, dg_sel = 0;
    logic [7:0] fill_idx = 0, dg_addr = 0;
    logic rsp_valid, rsp_hit, rsp_fault, mem_we, fill_req;
    logic [31:0] rsp_rdata, dg_rdata, err_addr;
    logic [4:0] fill_line;
    logic [15:0] err_status;

    vtc_lookup u0 (.*);

    int ntests = 0, nfail = 0;
    logic [31:0] mtag [NL];
    logic [31:0] mdata [NW];
    logic [15:0] mst = 0;
    logic [31:0] maddr = 0;

    task automatic chk(string rq, string what, logic [31:0] got, logic [31:0] exp);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_tag(bit s, bit w, logic [2:0] c, logic [13:0] id);
        return 32'h0008_0000 | (32'(s) << 20) | (32'(w) << 21) | (32'(c) << 22) | (32'(id) << 2);
    endfunction

    task automatic do_fill(int line);
        for (int w = 0; w < LW; w++) begin
            fill_we = 1; fill_idx = 8'(line * LW + w); fill_data = $urandom;
            mdata[line * LW + w] = fill_data;
            @(negedge clk);
        end
        fill_we = 0;
    endtask

    task automatic do_req(bit wr, logic [21:0] va, logic [31:0] wd, bit usr, logic [2:0] ctx,
                          bit ce, bit pv, bit pw, bit ps, bit pu, logic [1:0] pt);
        int line = int'(va[7:3]);
        int wi = int'(va[7:0]);
        logic [13:0] id = va[21:8];
        logic [31:0] t = mtag[line];
        bit cach = (pt == 0) && !pu && ce;
        bit ok = t[19] && (t[15:2] == id);
        bit prot = usr && t[20] && (t[24:22] != ctx);
        bit e_hit = 0, e_flt = 0, e_mem = 0, e_fill = 0;
        logic [31:0] e_rd = 0;
        string rq;
        if (!wr) begin
            if (cach && ok && prot) begin rq = "R5"; e_flt = 1; mtag[line][19] = 0; end
            else if (cach && ok) begin rq = "R3"; e_hit = 1; e_rd = mdata[wi]; end
            else if (cach && pv) begin rq = "R2"; e_fill = 1; mtag[line] = mk_tag(ps, pw, ctx, id); end
            else rq = cach ? "R4" : "R9";
        end else if (!pv) rq = "R4";
        else if (cach) begin
            if (ok && (!t[21] || prot)) begin rq = "R8"; e_flt = 1; mtag[line][19] = 0; end
            else if (ok) begin rq = "R6"; e_hit = 1; e_mem = 1; mdata[wi] = wd; end
            else begin rq = "R7"; e_mem = 1; mtag[line][19] = 0; end
        end else begin
            rq = "R9"; e_flt = !pw || (usr && ps); e_mem = !e_flt;
        end
        if (e_flt) begin mst |= wr ? 16'h8040 : 16'h0040; maddr = {8'd0, va, 2'b00}; end
        req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd; user_mode = usr;
        cur_ctx = ctx; cache_en = ce; pg_valid = pv; pg_writable = pw; pg_super = ps;
        pg_uncached = pu; pg_type = pt;
        @(negedge clk);
        req_valid = 0;
        chk("R12", "rsp_valid", 32'(rsp_valid), 1);
        chk(rq, "hit", 32'(rsp_hit), 32'(e_hit));
        chk(rq, "fault", 32'(rsp_fault), 32'(e_flt));
        chk(rq, "mem_we", 32'(mem_we), 32'(e_mem));
        chk(rq, "fill_req", 32'(fill_req), 32'(e_fill));
        if (e_fill) chk(rq, "fill_line", 32'(fill_line), 32'(line));
        if (!wr) chk(rq, "rdata", rsp_rdata, e_rd);
        chk(rq, "err_status", 32'(err_status), 32'(mst));
        chk(rq, "err_addr", err_addr, maddr);
        if (e_fill) do_fill(line);
    endtask

    task automatic dg_write(bit sel, int a, logic [31:0] wd);
        dg_en = 1; dg_we = 1; dg_sel = sel; dg_addr = 8'(a); dg_wdata = wd;
        @(negedge clk);
        dg_en = 0; dg_we = 0;
    endtask

    task automatic dg_read(bit sel, int a, output logic [31:0] v);
        dg_en = 1; dg_we = 0; dg_sel = sel; dg_addr = 8'(a);
        @(negedge clk);
        dg_en = 0;
        v = dg_rdata;
    endtask

    function automatic logic [21:0] va_of(int id, int line, int w);
        return {14'(id), 5'(line), 3'(w)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        for (int i = 0; i < NL; i++) mtag[i] = 0;
        for (int i = 0; i < NW; i++) mdata[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "err_status", 32'(err_status), 0);
        chk("R1", "err_addr", err_addr, 0);
        dg_read(0, 3 * LW, v); chk("R1", "tag after reset", v, 0);
        chk("R12", "rsp_valid idle", 32'(rsp_valid), 0);

        // R2 fill, then R3 hit, then R5 cross-context supervisor read
        do_req(0, va_of(1, 3, 2), 0, 0, 2, 1, 1, 1, 1, 0, 0);
        dg_read(0, 3 * LW, v); chk("R2", "filled tag", v, mk_tag(1, 1, 2, 1));
        do_req(0, va_of(1, 3, 6), 0, 0, 2, 1, 1, 1, 1, 0, 0);
        do_req(0, va_of(1, 3, 6), 0, 1, 1, 1, 1, 1, 1, 0, 0);
        dg_read(0, 3 * LW, v); chk("R5", "line invalidated", 32'(v[19]), 0);
        // R4 invalid page: no fill
        do_req(0, va_of(2, 9, 0), 0, 0, 0, 1, 0, 1, 0, 0, 0);
        dg_read(0, 9 * LW, v); chk("R4", "tag untouched", v, 0);
        // R6 write hit then read back
        do_req(0, va_of(1, 4, 0), 0, 0, 0, 1, 1, 1, 0, 0, 0);
        do_req(1, va_of(1, 4, 5), 32'hcafe_f00d, 0, 0, 1, 1, 1, 0, 0, 0);
        do_req(0, va_of(1, 4, 5), 0, 0, 0, 1, 1, 1, 0, 0, 0);
        // R8 write to read-only line
        do_req(0, va_of(1, 6, 0), 0, 0, 0, 1, 1, 0, 0, 0, 0);
        do_req(1, va_of(1, 6, 1), 32'h1234, 0, 0, 1, 1, 1, 0, 0, 0);
        dg_read(0, 6 * LW, v); chk("R8", "line invalidated", 32'(v[19]), 0);
        // R7 write miss invalidates
        do_req(1, va_of(2, 4, 1), 32'h55, 0, 0, 1, 1, 1, 0, 0, 0);
        dg_read(0, 4 * LW, v); chk("R7", "line invalidated", 32'(v[19]), 0);
        // R9 non-cacheable
        do_req(0, va_of(1, 8, 0), 0, 0, 0, 1, 1, 1, 0, 0, 0);
        do_req(0, va_of(1, 8, 0), 0, 0, 0, 1, 1, 1, 0, 0, 1);
        do_req(0, va_of(1, 8, 0), 0, 0, 0, 0, 1, 1, 0, 0, 0);
        do_req(1, va_of(1, 8, 0), 7, 1, 0, 1, 1, 1, 1, 1, 0);
        dg_read(0, 8 * LW, v); chk("R9", "tag kept", v, mtag[8]);
        // R10 masked diagnostic tag write
        dg_write(0, 5 * LW, 32'hffff_ffff);
        dg_read(0, 5 * LW, v); chk("R10", "masked tag", v, 32'h03f8_fffc);
        dg_write(0, 5 * LW, 0); mtag[5] = 0;
        // R11 diagnostic data write clears valid
        do_req(0, va_of(1, 7, 0), 0, 0, 0, 1, 1, 1, 0, 0, 0);
        dg_write(1, 7 * LW + 1, 32'hdead_beef);
        mdata[7 * LW + 1] = 32'hdead_beef; mtag[7][19] = 0;
        dg_read(1, 7 * LW + 1, v); chk("R11", "data word", v, 32'hdead_beef);
        dg_read(0, 7 * LW, v); chk("R11", "valid cleared", 32'(v[19]), 0);

        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom % 100);
            do_req(1'($urandom % 3 == 0), va_of(1 + int'($urandom % 2), int'($urandom % 4), int'($urandom % 8)),
                   $urandom, 1'($urandom % 2), 3'($urandom % 2), r < 92, ($urandom % 10) != 0,
                   ($urandom % 10) < 7, ($urandom % 10) < 3, ($urandom % 20) == 0,
                   (($urandom % 20) == 0) ? 2'd1 : 2'd0);
        end
        @(negedge clk);
        chk("R12", "rsp_valid drops", 32'(rsp_valid), 0);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule